// File: doc/BRIEF.md
# Message-Signaled Interrupt File

This block keeps the interrupt state of one hart for interrupts that arrive as memory writes. A producer writes an identity number to a 32-bit doorbell word, and the block sets that identity's pending bit. Software reaches the rest of the state through an indirect port: an 8-bit select index, write data and a write mask. The state is a delivery switch, a priority threshold, and one pending word and one enable word for each group of 32 identities.

From that state the block picks the most urgent identity. This is the lowest-numbered identity that is both pending and enabled and that passes the threshold. The block presents it on a top-interrupt output and raises an interrupt line when delivery is on. A one-cycle claim strobe retires the identity currently shown. The doorbell has a second word whose value is byte-swapped, so that producers of either byte order can signal.

The number of implemented identities is a parameter, up to 2048. Identity 0 is reserved and never becomes pending.

Top module: `msif_file`

## Requirements
- R1: After reset, all state reads as zero, `top_o` is 0, `irq_o` is low, `rp_err_o` is low and `rp_rdata_o` is 0.
- R2: A doorbell write to offset 0x000 with all four byte enables and data k (1 <= k < NUM_IDS) sets the pending bit of identity k. The bit is visible on the clock edge that takes the write.
- R3: A doorbell write to offset 0x004 has its four bytes reversed (byte 0 becomes byte 3) before it is used as an identity.
- R4: A doorbell write is ignored when the data is 0, when the data is NUM_IDS or more, when the byte enables are not 4'hF, or when the address matches neither offset. `db_rdata_o` always reads 0.
- R5: `top_o` holds identity t at bits 26:16 and again at bits 10:0, and zeros elsewhere. t is the lowest identity whose pending bit and enable bit are both set. `top_o` is 0 when no identity qualifies.
- R6: When the threshold is nonzero and no greater than NUM_IDS, only identities strictly below it qualify. A threshold of zero, or one above NUM_IDS, filters nothing.
- R7: A `claim_i` pulse clears the pending bit of the identity shown on `top_o` and does nothing when `top_o` is 0. A doorbell write of the same identity in the same cycle wins, and the bit stays set.
- R8: `irq_o` is high exactly when bit 0 of the delivery register is 1 and `top_o` is nonzero. Only bit 0 of the delivery register can be written.
- R9: A port access with `rp_valid_i` stores (old & ~mask) | (data & mask), limited to the writable bits. One cycle later it returns the old value on `rp_rdata_o`. A read is an access with mask 0. The threshold has 11 writable bits.
- R10: Bit 0 of pending word 0 and of enable word 0 is read-only zero. Bits for identities NUM_IDS and above are read-only zero.
- R11: The select map is: 0x70 delivery, 0x72 threshold, 0x80+w pending word w, 0xC0+w enable word w. Word w holds identities 32w to 32w+31, with identity 32w+b at bit b.
- R12: Any other select, or a word w that is not implemented (w >= ceil(NUM_IDS/32)), raises `rp_err_o` for one cycle one cycle later. It changes no state, and `rp_rdata_o` then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| db_wr_i | input | 1 | Doorbell write strobe |
| db_addr_i | input | DB_AW | Doorbell byte address |
| db_be_i | input | 4 | Doorbell byte enables |
| db_wdata_i | input | 32 | Doorbell write data (identity) |
| db_rdata_o | output | 32 | Doorbell read data, always zero |
| rp_valid_i | input | 1 | Register port access strobe |
| rp_sel_i | input | 8 | Register select index |
| rp_wdata_i | input | 32 | Register write data |
| rp_mask_i | input | 32 | Register write mask |
| rp_rdata_o | output | 32 | Old value of the accessed register, one cycle later |
| rp_err_o | output | 1 | One-cycle pulse for an unknown select |
| claim_i | input | 1 | Claim strobe for the current top identity |
| top_o | output | 32 | Top-interrupt value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_IDS = 48. That gives two pending words and two enable words, and the upper word is only half implemented. With this setting the read-only upper bits of word 1 can be observed, and select 0x81 is valid while 0x82 is rejected. A threshold equal to NUM_IDS (48) and one just above it (49) can both be reached, so the boundary of the filter rule is exercised on both sides. A doorbell value of 48 is the first out-of-range identity.

// File: rtl/msif_pkg.sv
package msif_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned ID_W     = 11;
   localparam int unsigned MAX_IDS  = 2048;

   localparam logic [7:0] SEL_DELIV  = 8'h70;
   localparam logic [7:0] SEL_THRESH = 8'h72;
   localparam logic [1:0] SEL_PEND_HI = 2'b10;  // 0x80..0xBF
   localparam logic [1:0] SEL_EN_HI   = 2'b11;  // 0xC0..0xFF

   localparam logic [WORD_W-1:0] DELIV_WMASK  = 32'h0000_0001;
   localparam logic [WORD_W-1:0] THRESH_WMASK = 32'h0000_07FF;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_DELIV,
      TGT_THRESH,
      TGT_PEND,
      TGT_EN
   } tgt_e;

   function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [WORD_W-1:0] masked_merge(input logic [WORD_W-1:0] old_v,
                                                      input logic [WORD_W-1:0] new_v,
                                                      input logic [WORD_W-1:0] msk);
      return (old_v & ~msk) | (new_v & msk);
   endfunction

endpackage

// File: rtl/msif_regsel.sv
module msif_regsel
   import msif_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 2,
   localparam int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic [7:0]        sel_i,
   output tgt_e              tgt_o,
   output logic [WIDX_W-1:0] widx_o
);

   logic word_ok;

   generate
      if (NUM_WORDS == 1) begin : g_single
         assign word_ok = (sel_i[5:0] == 6'd0);
         assign widx_o  = '0;
      end else begin : g_multi
         assign word_ok = (32'(sel_i[5:0]) < NUM_WORDS);
         assign widx_o  = sel_i[WIDX_W-1:0];
      end
   endgenerate

   always_comb begin
      tgt_o = TGT_NONE;
      if (sel_i == SEL_DELIV)
         tgt_o = TGT_DELIV;
      else if (sel_i == SEL_THRESH)
         tgt_o = TGT_THRESH;
      else if (sel_i[7:6] == SEL_PEND_HI && word_ok)
         tgt_o = TGT_PEND;
      else if (sel_i[7:6] == SEL_EN_HI && word_ok)
         tgt_o = TGT_EN;
   end

endmodule

// File: rtl/msif_doorbell.sv
module msif_doorbell
   import msif_pkg::*;
#(
   parameter int unsigned NUM_IDS = 64,
   parameter int unsigned AW      = 12,
   parameter int unsigned LE_OFF  = 0,
   parameter int unsigned BE_OFF  = 4,
   parameter int unsigned IX_W    = 6
) (
   input  logic              wr_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [3:0]        be_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic              set_o,
   output logic [IX_W-1:0]   ix_o
);

   logic              full_word;
   logic              hit_le;
   logic              hit_be;
   logic [WORD_W-1:0] ident;

   assign full_word = (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
   assign hit_le    = (addr_i == AW'(LE_OFF));
   assign hit_be    = (addr_i == AW'(BE_OFF));
   assign ident     = hit_be ? swap_bytes(wdata_i) : wdata_i;

   assign set_o = wr_i && full_word && (hit_le || hit_be) &&
                  (ident != '0) && (ident < NUM_IDS);
   assign ix_o  = ident[IX_W-1:0];

endmodule

// File: rtl/msif_prio.sv
module msif_prio
   import msif_pkg::*;
#(
   parameter int unsigned NUM_IDS  = 64,
   parameter int unsigned NUM_BITS = 64,
   parameter int unsigned IX_W     = 6
) (
   input  logic [NUM_BITS-1:0] pend_i,
   input  logic [NUM_BITS-1:0] en_i,
   input  logic [WORD_W-1:0]   thr_i,
   output logic                found_o,
   output logic [IX_W-1:0]     ix_o
);

   logic                use_thr;
   logic [NUM_BITS-1:0] elig;

   assign use_thr = (thr_i != '0) && (thr_i <= NUM_IDS);

   always_comb begin
      for (int i = 0; i < NUM_BITS; i++) begin
         elig[i] = pend_i[i] && en_i[i] && (i != 0) && (i < NUM_IDS) &&
                   (!use_thr || (32'(i) < thr_i));
      end
   end

   // scan from the top so the lowest eligible index is the last one kept
   always_comb begin
      found_o = 1'b0;
      ix_o    = '0;
      for (int i = NUM_BITS - 1; i >= 0; i--) begin
         if (elig[i]) begin
            found_o = 1'b1;
            ix_o    = IX_W'(i);
         end
      end
   end

endmodule

// File: rtl/msif_file.sv
module msif_file
   import msif_pkg::*;
#(
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned DB_AW     = 12,
   parameter int unsigned DB_LE_OFF = 0,
   parameter int unsigned DB_BE_OFF = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              db_wr_i,
   input  logic [DB_AW-1:0]  db_addr_i,
   input  logic [3:0]        db_be_i,
   input  logic [WORD_W-1:0] db_wdata_i,
   output logic [WORD_W-1:0] db_rdata_o,
   input  logic              rp_valid_i,
   input  logic [7:0]        rp_sel_i,
   input  logic [WORD_W-1:0] rp_wdata_i,
   input  logic [WORD_W-1:0] rp_mask_i,
   output logic [WORD_W-1:0] rp_rdata_o,
   output logic              rp_err_o,
   input  logic              claim_i,
   output logic [WORD_W-1:0] top_o,
   output logic              irq_o
);

   localparam int unsigned NUM_WORDS = (NUM_IDS + WORD_W - 1) / WORD_W;
   localparam int unsigned NUM_BITS  = NUM_WORDS * WORD_W;
   localparam int unsigned IX_W      = $clog2(NUM_BITS);
   localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   // elaboration checks
   generate
      if (NUM_IDS < 2 || NUM_IDS > MAX_IDS) begin : g_bad_ids
         $error("NUM_IDS must lie in 2..2048");
      end
      if (DB_LE_OFF == DB_BE_OFF) begin : g_bad_off
         $error("doorbell offsets must differ");
      end
      if ((DB_LE_OFF % 4) != 0 || (DB_BE_OFF % 4) != 0) begin : g_bad_align
         $error("doorbell offsets must be word aligned");
      end
      if (DB_AW < 3 || DB_AW > 32) begin : g_bad_aw
         $error("DB_AW must lie in 3..32");
      end
   endgenerate

   function automatic logic [NUM_WORDS-1:0][WORD_W-1:0] build_wmask();
      logic [NUM_WORDS-1:0][WORD_W-1:0] m;
      for (int w = 0; w < NUM_WORDS; w++) begin
         for (int b = 0; b < WORD_W; b++) begin
            m[w][b] = ((w * 32 + b) != 0) && ((w * 32 + b) < NUM_IDS);
         end
      end
      return m;
   endfunction

   localparam logic [NUM_WORDS-1:0][WORD_W-1:0] WORD_WMASK = build_wmask();

   // state
   logic [WORD_W-1:0]   deliv_q;
   logic [WORD_W-1:0]   thr_q;
   logic [NUM_BITS-1:0] pend_flat;
   logic [NUM_BITS-1:0] en_flat;
   logic [WORD_W-1:0]   rdata_q;
   logic                err_q;

   // register port decode
   tgt_e              tgt;
   logic [WIDX_W-1:0] widx;
   logic              acc_ok;
   logic [WORD_W-1:0] old_val;
   logic [WORD_W-1:0] new_val;

   msif_regsel #(
      .NUM_WORDS (NUM_WORDS)
   ) u_regsel (
      .sel_i  (rp_sel_i),
      .tgt_o  (tgt),
      .widx_o (widx)
   );

   assign acc_ok = rp_valid_i && (tgt != TGT_NONE);

   always_comb begin
      old_val = '0;
      case (tgt)
         TGT_DELIV:  old_val = deliv_q;
         TGT_THRESH: old_val = thr_q;
         TGT_PEND:   old_val = pend_flat[32*widx +: 32];
         TGT_EN:     old_val = en_flat[32*widx +: 32];
         default:    old_val = '0;
      endcase
   end

   assign new_val = masked_merge(old_val, rp_wdata_i, rp_mask_i);

   // doorbell
   logic            db_set;
   logic [IX_W-1:0] db_ix;

   msif_doorbell #(
      .NUM_IDS (NUM_IDS),
      .AW      (DB_AW),
      .LE_OFF  (DB_LE_OFF),
      .BE_OFF  (DB_BE_OFF),
      .IX_W    (IX_W)
   ) u_db (
      .wr_i    (db_wr_i),
      .addr_i  (db_addr_i),
      .be_i    (db_be_i),
      .wdata_i (db_wdata_i),
      .set_o   (db_set),
      .ix_o    (db_ix)
   );

   assign db_rdata_o = '0;

   // priority selection
   logic            top_found;
   logic [IX_W-1:0] top_ix;

   msif_prio #(
      .NUM_IDS  (NUM_IDS),
      .NUM_BITS (NUM_BITS),
      .IX_W     (IX_W)
   ) u_prio (
      .pend_i  (pend_flat),
      .en_i    (en_flat),
      .thr_i   (thr_q),
      .found_o (top_found),
      .ix_o    (top_ix)
   );

   logic [ID_W-1:0] top_id;
   assign top_id = ID_W'(top_ix);
   assign top_o  = top_found ? {5'b0, top_id, 5'b0, top_id} : '0;
   assign irq_o  = deliv_q[0] && top_found;

   // one-hot set and clear vectors; register write, then claim, then doorbell
   logic [NUM_BITS-1:0] clr_vec;
   logic [NUM_BITS-1:0] set_vec;

   assign clr_vec = (claim_i && top_found) ? (NUM_BITS'(1) << top_ix) : '0;
   assign set_vec = db_set ? (NUM_BITS'(1) << db_ix) : '0;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic              here;
         logic [WORD_W-1:0] p_q, e_q, p_nxt, e_nxt;

         assign here = (widx == WIDX_W'(w));

         always_comb begin
            p_nxt = p_q;
            e_nxt = e_q;
            if (acc_ok && tgt == TGT_PEND && here) p_nxt = new_val;
            if (acc_ok && tgt == TGT_EN && here)   e_nxt = new_val;
            p_nxt = (p_nxt & ~clr_vec[w*32 +: 32]) | set_vec[w*32 +: 32];
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               p_q <= '0;
               e_q <= '0;
            end else begin
               p_q <= p_nxt & WORD_WMASK[w];
               e_q <= e_nxt & WORD_WMASK[w];
            end
         end

         assign pend_flat[w*32 +: 32] = p_q;
         assign en_flat[w*32 +: 32]   = e_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         deliv_q <= '0;
         thr_q   <= '0;
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (acc_ok && tgt == TGT_DELIV)  deliv_q <= new_val & DELIV_WMASK;
         if (acc_ok && tgt == TGT_THRESH) thr_q   <= new_val & THRESH_WMASK;
         rdata_q <= acc_ok ? old_val : '0;
         err_q   <= rp_valid_i && (tgt == TGT_NONE);
      end
   end

   assign rp_rdata_o = rdata_q;
   assign rp_err_o   = err_q;

   // assertions

   // R2
   db_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      db_set |=> pend_flat[$past(db_ix)]);

   // R7
   claim_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_i && top_found && !(db_set && db_ix == top_ix)) |=> !pend_flat[$past(top_ix)]);

   // R12
   bad_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rp_valid_i && tgt == TGT_NONE) |=>
         (rp_err_o && deliv_q == $past(deliv_q) && thr_q == $past(thr_q) &&
          en_flat == $past(en_flat)));

   // R5
   top_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      top_found |-> (pend_flat[top_ix] && en_flat[top_ix] && top_ix != '0));

   // R6
   top_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (top_found && thr_q != '0 && thr_q <= NUM_IDS) |-> (32'(top_ix) < thr_q));

   // R10
   id0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_flat[0] && !en_flat[0]);

endmodule

// File: tb/sim_msif_file.sv
`timescale 1ns/100ps
module sim_msif_file;

   localparam int unsigned N_IDS = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        db_wr = 1'b0;
   logic [11:0] db_addr = '0;
   logic [3:0]  db_be = '0;
   logic [31:0] db_wdata = '0;
   logic [31:0] db_rdata;
   logic        rp_valid = 1'b0;
   logic [7:0]  rp_sel = '0;
   logic [31:0] rp_wdata = '0;
   logic [31:0] rp_mask = '0;
   logic [31:0] rp_rdata;
   logic        rp_err;
   logic        claim = 1'b0;
   logic [31:0] top;
   logic        irq;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   msif_file #(.NUM_IDS(N_IDS)) u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .db_wr_i    (db_wr),
      .db_addr_i  (db_addr),
      .db_be_i    (db_be),
      .db_wdata_i (db_wdata),
      .db_rdata_o (db_rdata),
      .rp_valid_i (rp_valid),
      .rp_sel_i   (rp_sel),
      .rp_wdata_i (rp_wdata),
      .rp_mask_i  (rp_mask),
      .rp_rdata_o (rp_rdata),
      .rp_err_o   (rp_err),
      .claim_i    (claim),
      .top_o      (top),
      .irq_o      (irq)
   );

   typedef struct packed {
      logic [1:0]  op;      // 0 register, 1 doorbell LE, 2 doorbell BE, 3 claim
      logic [7:0]  sel;
      logic [31:0] data;
      logic [31:0] mask;
      logic [31:0] exp_rd;
      logic [31:0] exp_top;
      logic        exp_irq;
      logic        exp_err;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VECS [0:NV-1] = '{
      '{2'd0, 8'h70, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0, 1'b0}, // R8 delivery on
      '{2'd0, 8'h70, 32'h0,         32'h0,         32'h1,         32'h0,         1'b0, 1'b0}, // R8 only bit 0 kept
      '{2'd0, 8'hC0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0, 1'b0}, // R11 enable word 0
      '{2'd0, 8'hC0, 32'h0,         32'h0,         32'hFFFF_FFFE, 32'h0,         1'b0, 1'b0}, // R10 id 0 enable zero
      '{2'd0, 8'hC1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0, 1'b0}, // R11 enable word 1
      '{2'd0, 8'hC1, 32'h0,         32'h0,         32'h0000_FFFF, 32'h0,         1'b0, 1'b0}, // R10 ids >= 48 zero
      '{2'd1, 8'h00, 32'd5,         32'h0,         32'h0,         32'h0005_0005, 1'b1, 1'b0}, // R2 id 5
      '{2'd2, 8'h00, 32'h0300_0000, 32'h0,         32'h0,         32'h0003_0003, 1'b1, 1'b0}, // R3 swapped id 3
      '{2'd1, 8'h00, 32'd0,         32'h0,         32'h0,         32'h0003_0003, 1'b1, 1'b0}, // R4 id 0 ignored
      '{2'd1, 8'h00, 32'd48,        32'h0,         32'h0,         32'h0003_0003, 1'b1, 1'b0}, // R4 id N ignored
      '{2'd1, 8'h00, 32'd40,        32'h0,         32'h0,         32'h0003_0003, 1'b1, 1'b0}, // R5 id 40 lower priority
      '{2'd0, 8'h80, 32'h0,         32'h0,         32'h0000_0028, 32'h0003_0003, 1'b1, 1'b0}, // R11 pending word 0
      '{2'd0, 8'h81, 32'h0,         32'h0,         32'h0000_0100, 32'h0003_0003, 1'b1, 1'b0}, // R11 pending word 1
      '{2'd0, 8'h72, 32'd4,         32'hFFFF_FFFF, 32'h0,         32'h0003_0003, 1'b1, 1'b0}, // R6 thr 4 passes 3
      '{2'd0, 8'h72, 32'd3,         32'hFFFF_FFFF, 32'd4,         32'h0,         1'b0, 1'b0}, // R6 thr 3 blocks 3
      '{2'd0, 8'h72, 32'd49,        32'hFFFF_FFFF, 32'd3,         32'h0003_0003, 1'b1, 1'b0}, // R6 thr above N
      '{2'd0, 8'h72, 32'hFFFF_FFFF, 32'h0000_000F, 32'h31,        32'h0003_0003, 1'b1, 1'b0}, // R9 partial mask
      '{2'd0, 8'h72, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3F,        32'h0003_0003, 1'b1, 1'b0}, // R9 11-bit threshold
      '{2'd0, 8'h72, 32'h0,         32'hFFFF_FFFF, 32'h7FF,       32'h0003_0003, 1'b1, 1'b0}, // R9 old value back
      '{2'd3, 8'h00, 32'h0,         32'h0,         32'h0,         32'h0005_0005, 1'b1, 1'b0}, // R7 claim 3
      '{2'd0, 8'hC0, 32'h0,         32'h0000_0020, 32'hFFFF_FFFE, 32'h0028_0028, 1'b1, 1'b0}, // R5 disable 5
      '{2'd3, 8'h00, 32'h0,         32'h0,         32'h0,         32'h0,         1'b0, 1'b0}, // R7 claim 40
      '{2'd0, 8'h80, 32'h1,         32'h1,         32'h0000_0020, 32'h0,         1'b0, 1'b0}, // R10 bit 0 write
      '{2'd0, 8'hC0, 32'hFFFF_FFFF, 32'h0000_0020, 32'hFFFF_FFDE, 32'h0005_0005, 1'b1, 1'b0}, // R5 enable 5
      '{2'd0, 8'h70, 32'h0,         32'h1,         32'h1,         32'h0005_0005, 1'b0, 1'b0}, // R8 delivery off
      '{2'd0, 8'h71, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0005_0005, 1'b0, 1'b1}, // R12 gap select
      '{2'd0, 8'h82, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0005_0005, 1'b0, 1'b1}, // R12 word 2 absent
      '{2'd0, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         32'h0005_0005, 1'b0, 1'b1}, // R12 select 0
      '{2'd0, 8'h70, 32'h0,         32'h0,         32'h0,         32'h0005_0005, 1'b0, 1'b0}, // R12 delivery unchanged
      '{2'd0, 8'hC0, 32'h0,         32'h0,         32'hFFFF_FFFE, 32'h0005_0005, 1'b0, 1'b0}  // R12 enable unchanged
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      db_wr = 1'b0; db_be = '0; db_addr = '0; db_wdata = '0;
      rp_valid = 1'b0; rp_sel = '0; rp_wdata = '0; rp_mask = '0;
      claim = 1'b0;
   endtask

   task automatic reg_op(input logic [7:0] s, input logic [31:0] d, input logic [31:0] m);
      @(negedge clk);
      rp_valid = 1'b1; rp_sel = s; rp_wdata = d; rp_mask = m;
      @(negedge clk);
      idle();
   endtask

   task automatic db_op(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      db_wr = 1'b1; db_addr = a; db_be = be; db_wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic claim_op();
      @(negedge clk);
      claim = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      case (v.op)
         2'd0: begin rp_valid = 1'b1; rp_sel = v.sel; rp_wdata = v.data; rp_mask = v.mask; end
         2'd1: begin db_wr = 1'b1; db_addr = 12'h000; db_be = 4'hF; db_wdata = v.data; end
         2'd2: begin db_wr = 1'b1; db_addr = 12'h004; db_be = 4'hF; db_wdata = v.data; end
         default: claim = 1'b1;
      endcase
      @(negedge clk);
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 top", top, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 err", {31'b0, rp_err}, 32'h0);
      chk("R1 rdata", rp_rdata, 32'h0);
      reg_op(8'h72, 32'h0, 32'h0);
      chk("R1 threshold", rp_rdata, 32'h0);
      reg_op(8'h80, 32'h0, 32'h0);
      chk("R1 pending", rp_rdata, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         chk($sformatf("vec %0d rdata", i), rp_rdata, VECS[i].exp_rd);
         chk($sformatf("vec %0d top", i), top, VECS[i].exp_top);
         chk($sformatf("vec %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
         chk($sformatf("vec %0d err", i), {31'b0, rp_err}, {31'b0, VECS[i].exp_err});
      end

      // R4 malformed doorbell accesses
      db_op(12'h002, 4'hF, 32'd7);
      db_op(12'h000, 4'h3, 32'd7);
      db_op(12'h008, 4'hF, 32'd7);
      reg_op(8'h80, 32'h0, 32'h0);
      chk("R4 malformed doorbell", rp_rdata, 32'h0000_0020);
      chk("R4 doorbell read", db_rdata, 32'h0);

      // R10 unimplemented bits of word 1
      reg_op(8'h81, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk("R10 pend1 old", rp_rdata, 32'h0);
      reg_op(8'h81, 32'h0, 32'h0);
      chk("R10 pend1 masked", rp_rdata, 32'h0000_FFFF);
      chk("R5 lowest wins", top, 32'h0005_0005);
      reg_op(8'h81, 32'h0, 32'hFFFF_FFFF);

      // R7 claim and doorbell of the same id together
      @(negedge clk);
      claim = 1'b1; db_wr = 1'b1; db_addr = 12'h000; db_be = 4'hF; db_wdata = 32'd5;
      @(negedge clk);
      idle();
      chk("R7 doorbell beats claim", top, 32'h0005_0005);

      // R6 threshold equal to N
      claim_op();
      chk("R7 claim empties", top, 32'h0);
      db_op(12'h000, 4'hF, 32'd47);
      chk("R2 id 47", top, 32'h002F_002F);
      reg_op(8'h72, 32'd47, 32'hFFFF_FFFF);
      chk("R6 thr 47 blocks 47", top, 32'h0);
      reg_op(8'h72, 32'd48, 32'hFFFF_FFFF);
      chk("R6 thr 48 old", rp_rdata, 32'd47);
      chk("R6 thr N passes 47", top, 32'h002F_002F);

      // R1 reset in mid run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 top in reset", top, 32'h0);
      rst_n = 1'b1;
      reg_op(8'hC0, 32'h0, 32'h0);
      chk("R1 enable cleared", rp_rdata, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule